// File: doc/BRIEF.md
# I2C Slave Clock-Stretch Controller

This block decides, for an I2C slave, when to hold the SCL line low and when to let it go. It watches the bus SCL through a synchronizer and finds the falling clock edges itself. The slave shifter supplies the bit position within the current byte, and the address logic supplies the match and read/write results. A small software-facing set of controls adds a release bit, three hold enables and a 10-bit update-address flag. The block drives one output, an open-drain pull-down enable for SCL, and it returns the release bit so that software can read it.

The pull-down is never applied to a line that is still high. When stretching is requested, the block waits until it has seen SCL low, which means another device has already pulled the clock down. Only then does it keep the line low. Several hardware events clear the release bit and start a stretch: a read request, the stretch-always mode, the address-hold mode and the data-hold mode. Software setting the release bit ends the stretch. A separate update-address flag stretches the clock without touching the release bit, and a write to the address register ends that stretch. A STOP condition returns everything to the idle state.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: While the release bit is 0 and SCL is sampled high, the pull-down stays off. It turns on only in the cycle after the synchronized SCL has been seen low.
- R2: Once the release bit is 1 (and the update-address flag is clear), the pull-down is off. SCL on the bus then rises only when the master also releases it, and the bus shows no extra SCL edges while a stretch is held.
- R3: On the falling SCL edge where bit position equals 8 (the ACK clock), during an address byte with address match 1 and read/write bit 1, the release bit is cleared. This happens whatever the state of the hold enables.
- R4: With stretch-always at 1, the release bit is cleared on every falling SCL edge where bit position equals 8.
- R5: Pulsing the update-address set input makes the block hold SCL low once SCL has been sampled low, while the release bit stays 1. An address-register write clears the flag, and the pull-down turns off in the cycle after the write.
- R6: With address-hold at 1, the release bit is cleared on the falling SCL edge where bit position equals 7, during an address byte with address match 1.
- R7: With data-hold at 1, the release bit is cleared on the falling SCL edge where bit position equals 7, during a data byte (address phase 0).
- R8: If a software write of 1 to the release bit falls in the same cycle as a hardware clear event, the release bit ends up 0.
- R9: Reset and a STOP pulse both leave the release bit at 1, the pull-down off and the update-address flag clear.
- R10: The release bit is not cleared in these cases: a non-matching address at position 7, an address-hold enable at position 7 during a data byte, a data-hold enable at position 8, and a read request at position 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL level seen on the bus |
| bitPos | input | 4 | Count of SCL falls already taken in the current byte, from the shifter |
| addrPhase | input | 1 | 1 while the current byte is an address byte |
| addrMatch | input | 1 | Address compare result for the current address byte |
| rwBit | input | 1 | Received read/write bit, 1 = read request |
| stretchAll | input | 1 | Stretch after every ACK clock |
| addrHoldEn | input | 1 | Hold after 8th fall of a matching address byte |
| dataHoldEn | input | 1 | Hold after 8th fall of a data byte |
| swRelWr | input | 1 | Software write strobe for the release bit |
| swRelVal | input | 1 | Value written to the release bit |
| uaSet | input | 1 | Pulse that sets the 10-bit update-address flag |
| addrRegWr | input | 1 | Address-register write strobe, clears the update-address flag |
| stopDet | input | 1 | STOP condition pulse |
| sclPullDown | output | 1 | Open-drain enable: 1 pulls SCL low |
| relBit | output | 1 | Readback of the release bit |

## Verification
A trigger decoded at the wrong bit position or for the wrong byte type shows up on relBit three cycles after the SCL fall reaches sclIn. That is two synchronizer stages plus one register. The same fault appears at the bus as a clock that stays low, or fails to stay low, as soon as the master lets SCL go. If the pull-down state machine fails to hold only after a low, the pull-down turns on while the master is still holding SCL high. That fault can be seen within one cycle. A flag that is never cleared, or a release that comes late, leaves SCL held low for a measurable number of cycles after the address write, the STOP or the software release.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
  typedef struct packed {
    logic hwClr;
    logic swLoad;
    logic swVal;
    logic uaSet;
    logic uaClr;
    logic stopRel;
  } stretch_strobe_t;
endpackage

// File: rtl/i2c_stretch_sync.sv
module i2c_stretch_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{INIT}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_stretch_trig.sv
module i2c_stretch_trig
  import i2c_stretch_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8,
  localparam int POS_W = $clog2(BITS_PER_BYTE + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclSync,
  input  logic [POS_W-1:0] bitPos,
  input  logic addrPhase,
  input  logic addrMatch,
  input  logic rwBit,
  input  logic stretchAll,
  input  logic addrHoldEn,
  input  logic dataHoldEn,
  input  logic swRelWr,
  input  logic swRelVal,
  input  logic uaSet,
  input  logic addrRegWr,
  input  logic stopDet,
  output stretch_strobe_t strb
);
  localparam logic [POS_W-1:0] POS_LAST_DATA = POS_W'(BITS_PER_BYTE - 1);
  localparam logic [POS_W-1:0] POS_ACK       = POS_W'(BITS_PER_BYTE);

  logic sclPrev;
  logic fallEv;
  logic atLastData;
  logic atAck;
  logic addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b1;
    else       sclPrev <= sclSync;
  end

  assign fallEv     = sclPrev & ~sclSync;
  assign atLastData = fallEv && (bitPos == POS_LAST_DATA);
  assign atAck      = fallEv && (bitPos == POS_ACK);
  assign addrHit    = addrPhase & addrMatch;

  always_comb begin
    strb = '0;
    strb.hwClr   = (atLastData && addrHit && addrHoldEn)
                 || (atLastData && !addrPhase && dataHoldEn)
                 || (atAck && addrHit && rwBit)
                 || (atAck && stretchAll);
    strb.swLoad  = swRelWr;
    strb.swVal   = swRelVal;
    strb.uaSet   = uaSet;
    strb.uaClr   = addrRegWr;
    strb.stopRel = stopDet;
  end
endmodule

// File: rtl/i2c_stretch_dp.sv
module i2c_stretch_dp
  import i2c_stretch_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclSync,
  input  stretch_strobe_t strb,
  output logic relBit,
  output logic uaFlag,
  output logic pullDown
);
  logic relNext;
  logic uaNext;
  logic pullNext;
  logic holdWant;

  always_comb begin
    if (strb.stopRel)     relNext = 1'b1;
    else if (strb.hwClr)  relNext = 1'b0;
    else if (strb.swLoad) relNext = strb.swVal;
    else                  relNext = relBit;

    if (strb.stopRel || strb.uaClr) uaNext = 1'b0;
    else if (strb.uaSet)            uaNext = 1'b1;
    else                            uaNext = uaFlag;

    holdWant = !relNext || uaNext;

    if (strb.stopRel || !holdWant) pullNext = 1'b0;
    else                           pullNext = pullDown || !sclSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relBit   <= 1'b1;
      uaFlag   <= 1'b0;
      pullDown <= 1'b0;
    end else begin
      relBit   <= relNext;
      uaFlag   <= uaNext;
      pullDown <= pullNext;
    end
  end
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
  import i2c_stretch_pkg::*;
#(
  parameter int BITS_PER_BYTE = 8,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W = $clog2(BITS_PER_BYTE + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic [POS_W-1:0] bitPos,
  input  logic addrPhase,
  input  logic addrMatch,
  input  logic rwBit,
  input  logic stretchAll,
  input  logic addrHoldEn,
  input  logic dataHoldEn,
  input  logic swRelWr,
  input  logic swRelVal,
  input  logic uaSet,
  input  logic addrRegWr,
  input  logic stopDet,
  output logic sclPullDown,
  output logic relBit
);
  logic sclSync;
  logic uaFlag;
  stretch_strobe_t strb;

  i2c_stretch_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync)
  );

  i2c_stretch_trig #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_trig (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .bitPos(bitPos),
    .addrPhase(addrPhase), .addrMatch(addrMatch), .rwBit(rwBit),
    .stretchAll(stretchAll), .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .swRelWr(swRelWr), .swRelVal(swRelVal), .uaSet(uaSet),
    .addrRegWr(addrRegWr), .stopDet(stopDet), .strb(strb)
  );

  i2c_stretch_dp u_dp (
    .clk(clk), .rstN(rstN), .sclSync(sclSync), .strb(strb),
    .relBit(relBit), .uaFlag(uaFlag), .pullDown(sclPullDown)
  );
endmodule

// File: rtl/i2c_stretch_checker.sv
module i2c_stretch_checker (
  input logic clk,
  input logic rstN,
  input logic sclPullDown,
  input logic relBit,
  input logic addrRegWr,
  input logic stopDet,
  input logic sclSync,
  input logic uaFlag
);
  // R1: a new hold only starts after SCL was sampled low
  assert_hold_after_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclPullDown) |-> !$past(sclSync));

  // R2: a rising release bit with no update-address flag means the line is free
  assert_release_frees_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(relBit) && !uaFlag) |-> !sclPullDown);

  // R5: address write ends an update-address stretch at once
  assert_addr_write_frees_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addrRegWr) && relBit) |-> !sclPullDown);

  // R5: the update-address flag keeps an active hold
  assert_ua_keeps_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (uaFlag && $past(uaFlag) && $past(sclPullDown)) |-> sclPullDown);

  // R9: STOP returns to idle
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (relBit && !sclPullDown && !uaFlag));
endmodule

bind i2c_stretch_ctrl i2c_stretch_checker u_chk (
  .clk(clk), .rstN(rstN), .sclPullDown(sclPullDown), .relBit(relBit),
  .addrRegWr(addrRegWr), .stopDet(stopDet), .sclSync(sclSync), .uaFlag(uaFlag)
);

// File: tb/i2c_stretch_ctrl_test.sv
module i2c_stretch_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1;
  logic [3:0] bitPos = '0;
  logic addrPhase = 0, addrMatch = 0, rwBit = 0;
  logic stretchAll = 0, addrHoldEn = 0, dataHoldEn = 0;
  logic swRelWr = 0, swRelVal = 0, uaSet = 0, addrRegWr = 0, stopDet = 0;
  logic sclPullDown, relBit;
  logic sclBus;
  int tests = 0, fails = 0;
  int edgeCnt = 0;
  logic busPrev = 1'b1;
  bit done = 0;

  assign sclBus = masterScl & ~sclPullDown;

  i2c_stretch_ctrl uut (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .bitPos(bitPos),
    .addrPhase(addrPhase), .addrMatch(addrMatch), .rwBit(rwBit),
    .stretchAll(stretchAll), .addrHoldEn(addrHoldEn), .dataHoldEn(dataHoldEn),
    .swRelWr(swRelWr), .swRelVal(swRelVal), .uaSet(uaSet),
    .addrRegWr(addrRegWr), .stopDet(stopDet),
    .sclPullDown(sclPullDown), .relBit(relBit)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    busPrev <= sclBus;
    if (sclBus != busPrev) edgeCnt <= edgeCnt + 1;
  end

  // fields: addrPhase, addrMatch, rwBit, stretchAll, addrHoldEn, dataHoldEn, bitPos[3:0], expClr, tag[3:0]
  typedef struct packed {
    logic ap, am, rw, sa, ah, dh;
    logic [3:0] pos;
    logic expClr;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,0,0,4'd7,1'b0,4'd10},
    '{1,1,0,0,1,0,4'd7,1'b1,4'd6},
    '{1,0,0,0,1,0,4'd7,1'b0,4'd10},
    '{0,0,0,0,0,1,4'd7,1'b1,4'd7},
    '{0,0,0,0,1,0,4'd7,1'b0,4'd10},
    '{1,1,1,0,0,0,4'd8,1'b1,4'd3},
    '{1,1,0,0,0,0,4'd8,1'b0,4'd10},
    '{0,0,0,1,0,0,4'd8,1'b1,4'd4},
    '{0,0,0,0,0,1,4'd8,1'b0,4'd10},
    '{1,1,1,0,0,0,4'd7,1'b0,4'd10}
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic swWrite(input logic v);
    swRelWr = 1; swRelVal = v;
    @(negedge clk);
    swRelWr = 0; swRelVal = 0;
  endtask

  task automatic clearCfg();
    {addrPhase, addrMatch, rwBit, stretchAll, addrHoldEn, dataHoldEn} = '0;
    bitPos = '0;
  endtask

  initial begin
    int e0;
    waitN(4);
    chk("R9 reset relBit", relBit, 1'b1);
    chk("R9 reset pull", sclPullDown, 1'b0);
    rstN = 1'b1;
    waitN(3);

    for (int v = 0; v < NV; v++) begin
      addrPhase = VECS[v].ap; addrMatch = VECS[v].am; rwBit = VECS[v].rw;
      stretchAll = VECS[v].sa; addrHoldEn = VECS[v].ah; dataHoldEn = VECS[v].dh;
      bitPos = VECS[v].pos;
      waitN(1);
      masterScl = 0;
      waitN(6);
      chk(tagName(VECS[v].tag), relBit, ~VECS[v].expClr);
      masterScl = 1;
      waitN(6);
      chk(tagName(VECS[v].tag), sclBus, ~VECS[v].expClr);
      if (VECS[v].expClr) begin
        e0 = edgeCnt;
        waitN(20);
        chk("R2 no edges while held", edgeCnt == e0, 1'b1);
        swWrite(1'b1);
        waitN(1);
        chk("R2 release", sclBus, 1'b1);
        e0 = edgeCnt;
        waitN(10);
        chk("R2 high time kept", edgeCnt == e0, 1'b1);
      end
      clearCfg();
      waitN(2);
    end

    // R1: clear release while SCL high: no pull
    swWrite(1'b0);
    waitN(10);
    chk("R1 no pull on high line", sclPullDown, 1'b0);
    chk("R1 bus high", sclBus, 1'b1);
    masterScl = 0;
    waitN(5);
    chk("R1 pull after low", sclPullDown, 1'b1);
    masterScl = 1;
    waitN(5);
    chk("R1 bus held", sclBus, 1'b0);
    swWrite(1'b1);
    waitN(2);
    chk("R2 sw release", sclBus, 1'b1);

    // R8: software set same cycle as hardware clear
    dataHoldEn = 1; bitPos = 4'd7;
    masterScl = 0;
    waitN(2);
    swWrite(1'b1);
    waitN(3);
    chk("R8 hw clear wins", relBit, 1'b0);
    masterScl = 1;
    waitN(4);
    chk("R8 bus held", sclBus, 1'b0);
    swWrite(1'b1);
    clearCfg();
    waitN(3);
    chk("R8 release after", sclBus, 1'b1);

    // R5: update-address stretch
    masterScl = 0;
    waitN(3);
    uaSet = 1; waitN(1); uaSet = 0;
    waitN(2);
    masterScl = 1;
    waitN(4);
    chk("R5 ua holds bus", sclBus, 1'b0);
    chk("R5 release bit kept", relBit, 1'b1);
    addrRegWr = 1; waitN(1); addrRegWr = 0;
    chk("R5 immediate release", sclPullDown, 1'b0);

    // R9: STOP releases hold and clears flag
    masterScl = 0;
    waitN(3);
    uaSet = 1; waitN(1); uaSet = 0;
    swWrite(1'b0);
    masterScl = 1;
    waitN(3);
    chk("R9 held before stop", sclBus, 1'b0);
    stopDet = 1; waitN(1); stopDet = 0;
    waitN(1);
    chk("R9 stop relBit", relBit, 1'b1);
    chk("R9 stop pull off", sclPullDown, 1'b0);
    masterScl = 0;
    waitN(5);
    masterScl = 1;
    waitN(3);
    chk("R9 ua flag cleared", sclBus, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule